// File: doc/BRIEF.md
# Watchdog Timer with Vector-Overlapped Service

This block is a watchdog for a small processor. It counts the crystal-derived clock through a power-of-two prescaler. If software does not service it within the selected period, it sends a one-cycle reset request to the system reset sequencer. To service it, software writes any data value to the service address, which is the top address of the bus. That same address also holds the low byte of the reset vector. A read there returns that byte, which is supplied on an input port, and a read does not service the watchdog. The watchdog never raises an interrupt.

Two configuration inputs control it: one turns the watchdog off, and one chooses the short or the long period. There are also power-mode inputs. Wait mode has no effect. Stop mode halts the counter and clears the prescaler. Monitor-mode entry can hold the watchdog off in two ways: for as long as the high test voltage is present, or, when entry came from blank vectors, until the next power-on reset. Each timeout lasts TICKS × 2^PRE_BITS clock cycles. With the defaults, that is 262,128 cycles for the long period and 8,176 cycles for the short one.

Top module: `wdog_vecsvc`

## Requirements
- R1: A write with any data to address SVC_ADDR (0xFFFF by default) clears the prescaler and the tick counter. If no further service arrives, `wdog_rst_o` is high right after the LONG_TICKS·2^PRE_BITS-th rising edge that follows the edge where the write was sampled.
- R2: A write to any other address does not affect the period.
- R3: While `bus_rd_i` is high with address SVC_ADDR, `bus_rdata_o` equals `rst_vec_lo_i` in the same cycle. For any other read it is 0x00. Reads never service the watchdog.
- R4: With `cfg_fast_i` = 1 the period is SHORT_TICKS·2^PRE_BITS edges. With 0 it is LONG_TICKS·2^PRE_BITS edges.
- R5: The reset request lasts exactly one cycle, and counting restarts at once. Without service, the next request comes one full period later.
- R6: While `cfg_off_i` is high, no request is issued. A full period starts from the last edge at which it was high.
- R7: `wait_i` has no effect on counting or on the timeout.
- R8: While `stop_i` is high, the prescaler is held at zero and the tick counter keeps its value, so no request is issued. After release, the remaining ticks are counted with a fresh prescaler. For example, after k edges of running, the request comes (period − ⌊k/2^PRE_BITS⌋·2^PRE_BITS) edges after the last stop edge.
- R9: When monitor entry (`mon_enter_i`) is sampled with `mon_hv_i` high, the watchdog is held off for as long as `mon_hv_i` stays high. A full period runs from the last edge at which it was high.
- R10: When monitor entry is sampled with `mon_hv_i` low, the watchdog is held off through system resets (`rst_ni`) until `por_ni` is asserted.
- R11: A service write sampled on the same edge as the terminal tick wins. No request is issued and a new period starts.
- R12: While `rst_ni` or `por_ni` is low, `wdog_rst_o` is low and the counters are cleared. The first request comes one full long period after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Crystal-derived input clock |
| por_ni | input | 1 | Power-on reset, active low, asynchronous |
| rst_ni | input | 1 | System reset, active low, asynchronous |
| bus_addr_i | input | ADDR_W | Bus address |
| bus_wr_i | input | 1 | Bus write strobe |
| bus_rd_i | input | 1 | Bus read strobe |
| bus_wdata_i | input | DATA_W | Bus write data (value is ignored) |
| bus_rdata_o | output | DATA_W | Read data: vector low byte on an address hit, zero otherwise |
| rst_vec_lo_i | input | DATA_W | Low byte of the reset vector |
| cfg_off_i | input | 1 | Configuration: watchdog off |
| cfg_fast_i | input | 1 | Configuration: 1 = short period, 0 = long period |
| wait_i | input | 1 | Wait mode indicator |
| stop_i | input | 1 | Stop mode indicator (clock to the watchdog halted) |
| mon_enter_i | input | 1 | One-cycle strobe: monitor mode entered |
| mon_hv_i | input | 1 | High test voltage present on the interrupt pin |
| wdog_rst_o | output | 1 | One-cycle reset request on timeout |

## Verification
The hardest case to reach from the ports is a service write that lands exactly on the terminal tick. The bench gets there by counting edges from a known service write and issuing the next write on edge period-th. It also places random service writes within one edge of the limit. A stop halfway through a prescaler phase is the other delicate case. The bench stops a few edges past a tick boundary, so that the lost prescaler count shows up as a shorter remaining period. Monitor holds are released on chosen edges, and the first later request is timed against them.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

   // Why the watchdog is being held off after monitor-mode entry
   typedef enum logic [1:0] {
      HOLD_NONE  = 2'd0,
      HOLD_VOLT  = 2'd1,
      HOLD_BLANK = 2'd2
   } hold_src_e;

   // Decoded bus events at the service address
   typedef struct packed {
      logic svc;     // write seen: restart the period
      logic rd_hit;  // read seen: return vector byte
   } bus_evt_t;

endpackage

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
   parameter int unsigned PRE_BITS = 4
) (
   input  logic clk_i,
   input  logic arst_ni,
   input  logic clr_i,
   output logic tick_o
);

   generate
      if (PRE_BITS == 0) begin : g_direct
         assign tick_o = !clr_i;
      end else begin : g_divide
         localparam logic [PRE_BITS-1:0] PRE_LAST = '1;
         logic [PRE_BITS-1:0] pre_q;

         always_ff @(posedge clk_i or negedge arst_ni) begin
            if (!arst_ni)   pre_q <= '0;
            else if (clr_i) pre_q <= '0;
            else            pre_q <= pre_q + 1'b1;
         end

         assign tick_o = !clr_i && (pre_q == PRE_LAST);

         // R8: a clear (stop, service, hold) leaves the prescaler at zero
         a_r8_prescale_cleared: assert property (@(posedge clk_i) disable iff (!arst_ni)
            clr_i |=> (pre_q == '0));
      end
   endgenerate

endmodule

// File: rtl/wdog_tickcount.sv
module wdog_tickcount #(
   parameter int unsigned LONG_TICKS  = 16383,
   parameter int unsigned SHORT_TICKS = 511
) (
   input  logic clk_i,
   input  logic arst_ni,
   input  logic clr_i,
   input  logic tick_i,
   input  logic fast_i,
   output logic expire_o
);

   localparam int unsigned MAX_TICKS = (LONG_TICKS > SHORT_TICKS) ? LONG_TICKS : SHORT_TICKS;
   localparam int unsigned CNT_W     = $clog2(MAX_TICKS);
   localparam logic [CNT_W-1:0] LONG_TERM  = CNT_W'(LONG_TICKS - 1);
   localparam logic [CNT_W-1:0] SHORT_TERM = CNT_W'(SHORT_TICKS - 1);
   localparam logic [CNT_W-1:0] MAX_TERM   = CNT_W'(MAX_TICKS - 1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] term;
   logic             at_term;
   logic             expire_q;

   assign term    = fast_i ? SHORT_TERM : LONG_TERM;
   // >= so that a switch to the short rate past its limit still ends the period
   assign at_term = tick_i && (cnt_q >= term);

   always_ff @(posedge clk_i or negedge arst_ni) begin
      if (!arst_ni) begin
         cnt_q    <= '0;
         expire_q <= 1'b0;
      end else if (clr_i) begin
         cnt_q    <= '0;
         expire_q <= 1'b0;
      end else if (at_term) begin
         cnt_q    <= '0;
         expire_q <= 1'b1;
      end else begin
         expire_q <= 1'b0;
         if (tick_i) cnt_q <= cnt_q + 1'b1;
      end
   end

   assign expire_o = expire_q;

   a_r5_single_cycle: assert property (@(posedge clk_i) disable iff (!arst_ni)
      expire_q |=> !expire_q);

   a_r5_count_restarts: assert property (@(posedge clk_i) disable iff (!arst_ni)
      expire_q |-> (cnt_q == '0));

   a_r11_clear_wins: assert property (@(posedge clk_i) disable iff (!arst_ni)
      clr_i |=> !expire_q);

   a_r4_count_bounded: assert property (@(posedge clk_i) disable iff (!arst_ni)
      cnt_q <= MAX_TERM);

endmodule

// File: rtl/wdog_monguard.sv
module wdog_monguard
   import wdog_pkg::*;
(
   input  logic clk_i,
   input  logic por_ni,
   input  logic mon_enter_i,
   input  logic mon_hv_i,
   output logic hold_o
);

   hold_src_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      if (state_q == HOLD_BLANK)        state_d = HOLD_BLANK;
      else if (mon_enter_i)             state_d = mon_hv_i ? HOLD_VOLT : HOLD_BLANK;
      else if (state_q == HOLD_VOLT && !mon_hv_i) state_d = HOLD_NONE;
   end

   // only a power-on reset releases a hold; system resets do not
   always_ff @(posedge clk_i or negedge por_ni) begin
      if (!por_ni) state_q <= HOLD_NONE;
      else         state_q <= state_d;
   end

   assign hold_o = mon_enter_i
                || (state_q == HOLD_BLANK)
                || (state_q == HOLD_VOLT && mon_hv_i);

   a_r10_blank_sticky: assert property (@(posedge clk_i) disable iff (!por_ni)
      (state_q == HOLD_BLANK) |=> (state_q == HOLD_BLANK));

   a_r9_volt_release: assert property (@(posedge clk_i) disable iff (!por_ni)
      (state_q == HOLD_VOLT && !mon_hv_i && !mon_enter_i) |=> (state_q == HOLD_NONE));

endmodule

// File: rtl/wdog_busdec.sv
module wdog_busdec
   import wdog_pkg::*;
#(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned DATA_W = 8,
   parameter logic [ADDR_W-1:0] SVC_ADDR = '1
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wr_i,
   input  logic              rd_i,
   input  logic [DATA_W-1:0] vec_lo_i,
   output bus_evt_t          evt_o,
   output logic [DATA_W-1:0] rdata_o
);

   logic hit;

   assign hit          = (addr_i == SVC_ADDR);
   assign evt_o.svc    = wr_i && hit;
   assign evt_o.rd_hit = rd_i && hit;
   assign rdata_o      = evt_o.rd_hit ? vec_lo_i : '0;

endmodule

// File: rtl/wdog_vecsvc.sv
module wdog_vecsvc
   import wdog_pkg::*;
#(
   parameter int unsigned ADDR_W      = 16,
   parameter int unsigned DATA_W      = 8,
   parameter logic [ADDR_W-1:0] SVC_ADDR = '1,
   parameter int unsigned PRE_BITS    = 4,
   parameter int unsigned LONG_TICKS  = 16383,
   parameter int unsigned SHORT_TICKS = 511
) (
   input  logic              clk_i,
   input  logic              por_ni,
   input  logic              rst_ni,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic              bus_wr_i,
   input  logic              bus_rd_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   output logic [DATA_W-1:0] bus_rdata_o,
   input  logic [DATA_W-1:0] rst_vec_lo_i,
   input  logic              cfg_off_i,
   input  logic              cfg_fast_i,
   input  logic              wait_i,
   input  logic              stop_i,
   input  logic              mon_enter_i,
   input  logic              mon_hv_i,
   output logic              wdog_rst_o
);

   generate
      if (LONG_TICKS < 2 || SHORT_TICKS < 2) begin : g_bad_ticks
         $error("wdog_vecsvc: tick limits must be at least 2");
      end
      if (PRE_BITS > 24) begin : g_bad_pre
         $error("wdog_vecsvc: PRE_BITS out of range");
      end
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_bus
         $error("wdog_vecsvc: bus widths must be non-zero");
      end
   endgenerate

   logic     arst_n;
   logic     mon_hold;
   logic     run_en;
   logic     cnt_clr;
   logic     pre_clr;
   logic     tick;
   logic     expire;
   bus_evt_t evt;

   // wait mode and write data do not change behaviour
   logic [DATA_W:0] unused_inputs;
   assign unused_inputs = {wait_i, bus_wdata_i};

   assign arst_n = rst_ni && por_ni;

   wdog_busdec #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .SVC_ADDR (SVC_ADDR)
   ) i_busdec (
      .addr_i   (bus_addr_i),
      .wr_i     (bus_wr_i),
      .rd_i     (bus_rd_i),
      .vec_lo_i (rst_vec_lo_i),
      .evt_o    (evt),
      .rdata_o  (bus_rdata_o)
   );

   wdog_monguard i_monguard (
      .clk_i       (clk_i),
      .por_ni      (por_ni),
      .mon_enter_i (mon_enter_i),
      .mon_hv_i    (mon_hv_i),
      .hold_o      (mon_hold)
   );

   assign run_en  = !cfg_off_i && !mon_hold;
   assign cnt_clr = evt.svc || !run_en;
   assign pre_clr = cnt_clr || stop_i;

   wdog_prescale #(
      .PRE_BITS (PRE_BITS)
   ) i_prescale (
      .clk_i   (clk_i),
      .arst_ni (arst_n),
      .clr_i   (pre_clr),
      .tick_o  (tick)
   );

   wdog_tickcount #(
      .LONG_TICKS  (LONG_TICKS),
      .SHORT_TICKS (SHORT_TICKS)
   ) i_tickcount (
      .clk_i    (clk_i),
      .arst_ni  (arst_n),
      .clr_i    (cnt_clr),
      .tick_i   (tick),
      .fast_i   (cfg_fast_i),
      .expire_o (expire)
   );

   assign wdog_rst_o = expire;

   a_r6_off_silent: assert property (@(posedge clk_i) disable iff (!arst_n)
      cfg_off_i |=> !wdog_rst_o);

   a_r8_stop_silent: assert property (@(posedge clk_i) disable iff (!arst_n)
      stop_i |=> !wdog_rst_o);

   a_r9_hold_silent: assert property (@(posedge clk_i) disable iff (!arst_n)
      mon_hold |=> !wdog_rst_o);

   a_r1_service_restart: assert property (@(posedge clk_i) disable iff (!arst_n)
      (bus_wr_i && bus_addr_i == SVC_ADDR) |=> !wdog_rst_o);

   a_r3_read_no_service: assert property (@(posedge clk_i) disable iff (!arst_n)
      (evt.rd_hit && !bus_wr_i) |-> !cnt_clr || !run_en);

endmodule

// File: tb/test_wdog_vecsvc.sv
module test_wdog_vecsvc;

   localparam int CLK_PERIOD = 10;
   localparam int PRE   = 2;
   localparam int LT    = 40;
   localparam int ST    = 10;

   function automatic int period(input int ticks);
      return ticks * (1 << PRE);
   endfunction

   function automatic int after_stop(input int ran, input int ticks);
      return period(ticks) - ((ran >> PRE) << PRE);
   endfunction

   localparam int NL = LT * (1 << PRE);
   localparam int NS = ST * (1 << PRE);

   logic        clk = 1'b0;
   logic        por_n = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic [7:0]  vec_lo = 8'h5A;
   logic        cfg_off = 1'b0;
   logic        cfg_fast = 1'b0;
   logic        wait_m = 1'b0;
   logic        stop_m = 1'b0;
   logic        mon_enter = 1'b0;
   logic        mon_hv = 1'b0;
   logic        wdog_rst;

   int checks = 0;
   int fails  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   wdog_vecsvc #(
      .ADDR_W(16), .DATA_W(8), .SVC_ADDR(16'hFFFF),
      .PRE_BITS(PRE), .LONG_TICKS(LT), .SHORT_TICKS(ST)
   ) i_wdog_vecsvc (
      .clk_i(clk), .por_ni(por_n), .rst_ni(rst_n),
      .bus_addr_i(bus_addr), .bus_wr_i(bus_wr), .bus_rd_i(bus_rd),
      .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
      .rst_vec_lo_i(vec_lo), .cfg_off_i(cfg_off), .cfg_fast_i(cfg_fast),
      .wait_i(wait_m), .stop_i(stop_m), .mon_enter_i(mon_enter),
      .mon_hv_i(mon_hv), .wdog_rst_o(wdog_rst)
   );

   // Run n edges; expect exactly one pulse after edge 'at' (0 = none)
   task automatic run_expect(input int n, input int at, input string tag);
      int first = 0;
      int hits  = 0;
      for (int i = 1; i <= n; i++) begin
         @(posedge clk); @(negedge clk);
         if (wdog_rst) begin
            hits++;
            if (first == 0) first = i;
         end
      end
      checks++;
      if (first != at || hits != ((at == 0) ? 0 : 1)) begin
         fails++;
         $display("FAIL %s: pulse at edge %0d (%0d pulses), expected edge %0d", tag, first, hits, at);
      end
   endtask

   task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk); @(negedge clk);
      bus_wr = 1'b0; bus_addr = '0;
   endtask

   task automatic bus_read(input logic [15:0] a, input logic [7:0] exp, input string tag);
      bus_addr = a; bus_rd = 1'b1;
      #1;
      checks++;
      if (bus_rdata !== exp) begin
         fails++;
         $display("FAIL %s: rdata %h, expected %h", tag, bus_rdata, exp);
      end
      @(posedge clk); @(negedge clk);
      bus_rd = 1'b0; bus_addr = '0;
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 200000);
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin : stim
      int unsigned seed_ack;
      int cur;
      int gap;
      seed_ack = $urandom(32'd1207);

      repeat (3) @(negedge clk);
      checks++;
      if (wdog_rst !== 1'b0) begin
         fails++;
         $display("FAIL R12 reset state: wdog_rst %b, expected 0", wdog_rst);
      end
      por_n = 1'b1; rst_n = 1'b1;
      run_expect(NL, NL, "R12 first long period after reset");
      run_expect(NL, NL, "R5 restart after pulse");

      bus_write(16'hFFFF, 8'h00);
      run_expect(NL, NL, "R1 service with zero data");
      bus_write(16'hFFFF, 8'hA5);
      run_expect(NL - 7, 0, "R1 no pulse before period");
      bus_write(16'hFFFF, 8'h3C);
      run_expect(NL, NL, "R1 reservice restarts");

      bus_write(16'hFFFF, 8'h11);
      run_expect(NL - 5, 0, "R2 before stray write");
      bus_write(16'hFFFE, 8'hFF);
      run_expect(4, 4, "R2 stray address does not service");

      bus_write(16'hFFFF, 8'h22);
      run_expect(NL - 6, 0, "R3 before reads");
      vec_lo = 8'hC3;
      bus_read(16'hFFFF, 8'hC3, "R3 vector byte read");
      bus_read(16'h00FF, 8'h00, "R3 other address reads zero");
      run_expect(4, 4, "R3 reads do not service");

      cfg_fast = 1'b1;
      bus_write(16'hFFFF, 8'h01);
      run_expect(NS, NS, "R4 short period");
      run_expect(NS, NS, "R4 R5 short period repeats");
      bus_write(16'hFFFF, 8'h02);
      run_expect(NS - 1, 0, "R11 short before terminal");
      bus_write(16'hFFFF, 8'h03);
      run_expect(NS, NS, "R11 short service on terminal wins");
      cfg_fast = 1'b0;
      bus_write(16'hFFFF, 8'h04);
      run_expect(NL, NL, "R4 long period");

      bus_write(16'hFFFF, 8'h05);
      run_expect(NL - 1, 0, "R11 long before terminal");
      bus_write(16'hFFFF, 8'h06);
      run_expect(NL, NL, "R11 service on terminal wins");

      wait_m = 1'b1;
      bus_write(16'hFFFF, 8'h07);
      run_expect(NL, NL, "R7 wait mode keeps counting");
      wait_m = 1'b0;

      bus_write(16'hFFFF, 8'h08);
      stop_m = 1'b1;
      run_expect(3 * NL, 0, "R8 stop holds");
      stop_m = 1'b0;
      run_expect(NL, NL, "R8 full period after stop");
      bus_write(16'hFFFF, 8'h09);
      run_expect(NL / 2 + 3, 0, "R8 before mid stop");
      stop_m = 1'b1;
      run_expect(5, 0, "R8 mid stop");
      stop_m = 1'b0;
      run_expect(after_stop(NL / 2 + 3, LT), after_stop(NL / 2 + 3, LT), "R8 resume keeps ticks, drops prescale");

      cfg_off = 1'b1;
      run_expect(2 * NL, 0, "R6 disabled");
      cfg_off = 1'b0;
      run_expect(NL, NL, "R6 full period after enable");

      mon_enter = 1'b1; mon_hv = 1'b1;
      @(posedge clk); @(negedge clk);
      mon_enter = 1'b0;
      run_expect(2 * NL, 0, "R9 held while voltage present");
      mon_hv = 1'b0;
      run_expect(NL, NL, "R9 period after voltage removed");

      cur = NL;
      for (int it = 0; it < 24; it++) begin
         cfg_fast = ($urandom % 2) != 0;
         cur = cfg_fast ? NS : NL;
         bus_write(16'hFFFF, 8'($urandom));
         gap = 1 + int'($urandom % (cur - 1));
         run_expect(gap, 0, "R1 R4 random service interval");
      end
      bus_write(16'hFFFF, 8'($urandom));
      run_expect(cur, cur, "R4 random mode final period");
      cfg_fast = 1'b0;

      mon_enter = 1'b1; mon_hv = 1'b0;
      @(posedge clk); @(negedge clk);
      mon_enter = 1'b0;
      run_expect(2 * NL, 0, "R10 blank hold");
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      run_expect(2 * NL, 0, "R10 hold survives system reset");
      por_n = 1'b0;
      repeat (3) @(negedge clk);
      por_n = 1'b1;
      run_expect(NL, NL, "R10 R12 power-on reset releases hold");

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule